// File: doc/BRIEF.md
# Configuration Lock Key Sequencer

This block sits behind the lock register of a pin-configuration port. It watches every bus access aimed at the lock address and tracks a fixed key sequence: three full-word writes with the key bit toggling 1, 0, 1, each carrying the same per-pin pattern, followed by a read. When that read arrives, the pattern becomes a frozen-pin mask. The port's mode, output-type, speed, pull and function-select registers, which live outside this block, use the mask to refuse further changes to the frozen pins.

Any step that breaks the sequence sends the sequencer back to its idle state. Breaking steps are a sub-word write to the lock address, a pattern that differs from the one already captured, a write with the wrong key value, or a read that comes too early. After an abort, locking needs a fresh sequence from the first write. Accesses to other addresses are transparent. Once locked, the key bit reads 1, the pattern can no longer be written, and only a reset releases the lock. A second read after the locking read returns the locked value and changes nothing.

Top module: `cfg_lock_seq`

## Requirements
- R1: After reset, `frozen_mask` is all zero and `lock_rdata` is zero.
- R2: While unlocked, a full-word write (`acc_size`=2) to the lock address stores `acc_wdata[15:0]` as the pattern. From the next cycle, `lock_rdata[15:0]` shows that pattern, bit 16 reads 0 and bits 31:17 read 0, whatever was written there.
- R3: The order write(bit16=1,P), write(bit16=0,P), write(bit16=1,P), read makes `frozen_mask`=P and `lock_rdata`=0x10000|P in the cycle after the read. Before that read, `frozen_mask` stays zero.
- R4: A byte (`acc_size`=0) or half-word (`acc_size`=1) write to the lock address aborts any sequence in progress and leaves the stored pattern unchanged.
- R5: A sequence write whose bits 15:0 differ from the pattern captured by the previous sequence write aborts the sequence.
- R6: A write with the wrong key value for its step, or a read before the third write, aborts the sequence. The steps that follow an abort do not lock, and a complete new sequence does lock.
- R7: Accesses of any kind to other addresses neither abort a sequence nor change `lock_rdata`.
- R8: Once locked, every access leaves `frozen_mask` and `lock_rdata` unchanged until reset. This includes writes of any size, key or pattern, and further reads.
- R9: Reset releases a lock, and a new sequence can then lock a different pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A bus access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Access address |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 treated as sub-word |
| acc_wdata | input | 32 | Write data |
| frozen_mask | output | 16 | Per-pin freeze mask for the configuration registers |
| lock_rdata | output | 32 | Lock register read value: bit 16 key, bits 15:0 pattern |

## Verification
The bench builds the block with its defaults: 16 pins, 8-bit addresses, 32-bit data and the lock address at 0x1C. With 16 pins, every single-pin lock pattern can be swept, each with a reset in between. Every pairing of the four sequence steps with four kinds of deviation can also be enumerated. After each deviation the bench checks that no lock occurred and that a clean sequence still locks. Separate runs insert foreign-address traffic between steps and hammer a locked port with writes and reads.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  typedef enum logic [2:0] {
    LK_IDLE      = 3'd0,
    LK_ARMED     = 3'd1,
    LK_DISARMED  = 3'd2,
    LK_REARMED   = 3'd3,
    LK_FROZEN    = 3'd4
  } lk_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic wr_full;
    logic wr_part;
    logic rd;
  } lk_event_t;

endpackage

// File: rtl/lock_access_decode.sv
module lock_access_decode
  import cfg_lock_pkg::*;
#(
  parameter int PINS      = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h1C
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output lk_event_t         ev,
  output logic              key_val,
  output logic [PINS-1:0]   pat_val
);
  localparam int KEY_POS = PINS;

  logic hit;
  logic unused_hi;

  assign hit       = acc_valid && (acc_addr == LOCK_ADDR);
  assign unused_hi = ^acc_wdata[DATA_W-1:KEY_POS+1];

  always_comb begin
    ev         = '0;
    ev.wr_full = hit && acc_write && (acc_size == SZ_WORD);
    ev.wr_part = hit && acc_write && (acc_size != SZ_WORD);
    ev.rd      = hit && !acc_write;
  end

  assign key_val = acc_wdata[KEY_POS];
  assign pat_val = acc_wdata[PINS-1:0];

endmodule

// File: rtl/lock_key_fsm.sv
module lock_key_fsm
  import cfg_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lk_event_t ev,
  input  logic      key_val,
  input  logic      pat_match,
  output lk_state_e state_q,
  output logic      lock_fire,
  output logic      locked
);
  lk_state_e state_n;
  logic      any_ev;

  assign any_ev = ev.wr_full || ev.wr_part || ev.rd;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      LK_IDLE: begin
        if (ev.wr_full && key_val) state_n = LK_ARMED;
      end
      LK_ARMED: begin
        if (ev.wr_full && !key_val && pat_match) state_n = LK_DISARMED;
        else if (any_ev)                         state_n = LK_IDLE;
      end
      LK_DISARMED: begin
        if (ev.wr_full && key_val && pat_match) state_n = LK_REARMED;
        else if (any_ev)                        state_n = LK_IDLE;
      end
      LK_REARMED: begin
        if (ev.rd)        state_n = LK_FROZEN;
        else if (any_ev)  state_n = LK_IDLE;
      end
      LK_FROZEN: state_n = LK_FROZEN;
      default:   state_n = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_IDLE;
    else     state_q <= state_n;
  end

  assign lock_fire = (state_q == LK_REARMED) && ev.rd;
  assign locked    = (state_q == LK_FROZEN);

  // R4
  partial_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (ev.wr_part && state_q != LK_FROZEN) |=> state_q == LK_IDLE);

  // R6
  early_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ev.rd && (state_q == LK_ARMED || state_q == LK_DISARMED)) |=> state_q == LK_IDLE);

  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == LK_FROZEN) |-> $past(state_q) == LK_REARMED);

  // R8
  frozen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == LK_FROZEN |=> state_q == LK_FROZEN);

  // R7
  foreign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_ev |=> $stable(state_q));

endmodule

// File: rtl/lock_reg_bank.sv
module lock_reg_bank #(
  parameter int PINS   = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_full,
  input  logic [PINS-1:0]   pat_val,
  input  logic              lock_fire,
  input  logic              locked,
  output logic [PINS-1:0]   pat_q,
  output logic [PINS-1:0]   frozen_mask,
  output logic [DATA_W-1:0] lock_rdata
);
  localparam int KEY_POS = PINS;

  logic              pat_we;
  logic [PINS-1:0]   pat_n;
  logic              key_n;
  logic [DATA_W-1:0] rdata_n;

  assign pat_we = wr_full && !locked;
  assign pat_n  = pat_we ? pat_val : pat_q;
  assign key_n  = locked || lock_fire;

  always_comb begin
    rdata_n                 = '0;
    rdata_n[PINS-1:0]       = pat_n;
    rdata_n[KEY_POS]        = key_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q       <= '0;
      frozen_mask <= '0;
      lock_rdata  <= '0;
    end else begin
      pat_q      <= pat_n;
      lock_rdata <= rdata_n;
      if (lock_fire) frozen_mask <= pat_q;
    end
  end

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(frozen_mask) && $stable(lock_rdata)));

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !locked |-> frozen_mask == '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (frozen_mask == '0 && lock_rdata == '0));

endmodule

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
  import cfg_lock_pkg::*;
#(
  parameter int PINS      = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [PINS-1:0]   frozen_mask,
  output logic [DATA_W-1:0] lock_rdata
);
  lk_event_t       ev;
  logic            key_val;
  logic [PINS-1:0] pat_val;
  logic [PINS-1:0] pat_q;
  logic            pat_match;
  lk_state_e       state_q;
  logic            lock_fire;
  logic            locked;
  logic            unused_state;

  lock_access_decode #(
    .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR)
  ) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .ev        (ev),
    .key_val   (key_val),
    .pat_val   (pat_val)
  );

  assign pat_match = (pat_val == pat_q);

  lock_key_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .key_val   (key_val),
    .pat_match (pat_match),
    .state_q   (state_q),
    .lock_fire (lock_fire),
    .locked    (locked)
  );

  assign unused_state = ^state_q;

  lock_reg_bank #(
    .PINS(PINS), .DATA_W(DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_full     (ev.wr_full),
    .pat_val     (pat_val),
    .lock_fire   (lock_fire),
    .locked      (locked),
    .pat_q       (pat_q),
    .frozen_mask (frozen_mask),
    .lock_rdata  (lock_rdata)
  );

endmodule

// File: tb/cfg_lock_seq_tb.sv
module cfg_lock_seq_tb;
  localparam logic [7:0] LADDR = 8'h1C;
  localparam logic [7:0] OADDR = 8'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [15:0] frozen_mask;
  logic [31:0] lock_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_lock_seq u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .frozen_mask(frozen_mask), .lock_rdata(lock_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
  endtask

  task automatic wr_word(input bit key, input logic [15:0] p);
    acc(1'b1, LADDR, 2'd2, {15'h0, key, p});
  endtask

  task automatic rd_lock();
    acc(1'b0, LADDR, 2'd2, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic full_seq(input logic [15:0] p);
    wr_word(1'b1, p); wr_word(1'b0, p); wr_word(1'b1, p); rd_lock();
  endtask

  // kind: 0 partial write, 1 changed pattern, 2 wrong key, 3 read (or extra write at step 3)
  task automatic seq_step(input int s, input int kind, input bit dev, input logic [15:0] p);
    bit          k;
    logic [15:0] q;
    k = (s == 1) ? 1'b0 : 1'b1;
    q = p ^ 16'h0100;
    if (!dev) begin
      if (s == 3) rd_lock(); else wr_word(k, p);
    end else begin
      case (kind)
        0: acc(1'b1, LADDR, 2'd1, {15'h0, (s == 3) ? 1'b1 : k, p});
        1: wr_word((s == 3) ? 1'b1 : k, q);
        2: wr_word((s == 3) ? 1'b0 : ~k, p);
        default: if (s == 3) wr_word(1'b1, p); else rd_lock();
      endcase
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] p;
    do_reset();
    // R1 reset state
    chk("R1 mask", {16'h0, frozen_mask}, 32'h0);
    chk("R1 rdata", lock_rdata, 32'h0);

    // R2 readback, reserved bits and key read 0
    acc(1'b1, LADDR, 2'd2, 32'hFFFE_1234);
    chk("R2 readback", lock_rdata, 32'h0000_1234);
    acc(1'b1, LADDR, 2'd2, 32'hFFFF_ABCD);
    chk("R2 key reads 0 before lock", lock_rdata, 32'h0000_ABCD);
    // R4 partial write keeps pattern
    acc(1'b1, LADDR, 2'd1, 32'h0000_5555);
    chk("R4 partial no store", lock_rdata, 32'h0000_ABCD);
    acc(1'b1, LADDR, 2'd0, 32'h0001_7777);
    chk("R4 byte no store", lock_rdata, 32'h0000_ABCD);

    // R3 single-pin sweep
    for (int i = 0; i < 16; i++) begin
      do_reset();
      p = 16'h1 << i;
      wr_word(1'b1, p); wr_word(1'b0, p); wr_word(1'b1, p);
      chk("R3 no mask before read", {16'h0, frozen_mask}, 32'h0);
      rd_lock();
      chk("R3 mask", {16'h0, frozen_mask}, {16'h0, p});
      chk("R3 rdata", lock_rdata, 32'h0001_0000 | {16'h0, p});
    end

    // R4 R5 R6 deviation sweep
    for (int s = 0; s < 4; s++) begin
      for (int kind = 0; kind < 4; kind++) begin
        do_reset();
        p = 16'h5A0F;
        for (int t = 0; t < 4; t++) seq_step(t, kind, t == s, p);
        rd_lock();
        if (kind == 0) begin
          chk("R4 abort mask", {16'h0, frozen_mask}, 32'h0);
          chk("R4 abort key", {31'h0, lock_rdata[16]}, 32'h0);
        end else if (kind == 1) begin
          chk("R5 abort mask", {16'h0, frozen_mask}, 32'h0);
          chk("R5 abort key", {31'h0, lock_rdata[16]}, 32'h0);
        end else begin
          chk("R6 abort mask", {16'h0, frozen_mask}, 32'h0);
          chk("R6 abort key", {31'h0, lock_rdata[16]}, 32'h0);
        end
        full_seq(16'h3C81);
        chk("R6 relock after abort", {16'h0, frozen_mask}, 32'h0000_3C81);
      end
    end

    // R7 foreign traffic between steps
    do_reset();
    p = 16'h9E61;
    wr_word(1'b1, p);
    acc(1'b1, OADDR, 2'd2, 32'hFFFF_FFFF);
    chk("R7 foreign write no effect", lock_rdata, {16'h0, p});
    acc(1'b0, OADDR, 2'd2, 32'h0);
    wr_word(1'b0, p);
    acc(1'b1, OADDR, 2'd1, 32'h0001_0000);
    wr_word(1'b1, p);
    acc(1'b0, OADDR, 2'd0, 32'h0);
    rd_lock();
    chk("R7 lock despite foreign", {16'h0, frozen_mask}, {16'h0, p});

    // R8 locked state is frozen
    do_reset();
    p = 16'hC3A5;
    full_seq(p);
    rd_lock();
    chk("R8 second read", lock_rdata, 32'h0001_C3A5);
    wr_word(1'b0, 16'h0000);
    chk("R8 write ignored", lock_rdata, 32'h0001_C3A5);
    acc(1'b1, LADDR, 2'd0, 32'h0000_00FF);
    chk("R8 partial ignored", lock_rdata, 32'h0001_C3A5);
    full_seq(16'h1111);
    chk("R8 mask held", {16'h0, frozen_mask}, 32'h0000_C3A5);
    chk("R8 rdata held", lock_rdata, 32'h0001_C3A5);

    // R9 reset releases
    do_reset();
    chk("R9 mask cleared", {16'h0, frozen_mask}, 32'h0);
    chk("R9 rdata cleared", lock_rdata, 32'h0);
    full_seq(16'h0FF0);
    chk("R9 relock", {16'h0, frozen_mask}, 32'h0000_0FF0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule